// File: doc/BRIEF.md
# Configurable GPIO Port

This block is one 8-bit port of general-purpose pins. Software programs it over a small register bus. Each pin has five settings:

- a direction bit;
- an output latch bit;
- a pull-up request bit;
- an open-drain bit;
- an input-gate bit that decides whether on-chip peripherals may see the pin.

The pad side gets a drive value, a drive enable and a pull-up enable for every pin. In return the pad sends back the level it senses on the pin.

Pad inputs first pass through a two-flop synchronizer. After that they feed two places: a read-only pin-level register, and a set of gated outputs towards peripherals. The gated outputs stay at zero until software opens the matching gate bit.

The port has an optional compatibility variant. In that variant the pin-level register reports the latch value for every pin set as an output.

Top module: `gpio_port`

## Requirements
- R1: After reset all five setting registers read 0, `busRdata` is 0, and `padOe`, `padPullUp` and `periphIn` are all 0.
- R2: Register offset 0 holds the direction bits. A 1 makes the pin an output (`padOe` high unless R6 applies), and the value written reads back unchanged.
- R3: Offset 1 holds the output latch. Reading it returns the latch value, never the sensed pin level.
- R4: Offset 5 returns the pin levels after a two-flop synchronizer. A read issued on the edge that follows a pad change still returns the old level for two consecutive reads.
- R5: Offset 2 holds the pull-up requests. `padPullUp` is high only where the request bit is 1 and the pin is an input; it is always low on outputs.
- R6: Offset 3 holds the open-drain bits. On an output pin with its open-drain bit at 1, `padOe` is high only while the latch bit is 0.
- R7: Offset 4 holds the input gates. `periphIn` of a pin is the synchronized level when its gate bit is 1, and a constant 0 otherwise.
- R8: `padOut` always equals the latch, whatever the direction. Changing the direction alone never changes `padOut`.
- R9: With `LATCH_ON_OUT`=1, offset 5 returns the latch bit for output pins and the synchronized level for input pins.
- R10: Writes to offset 5 and to offsets 6 and 7 change no register. Reads of offsets 6 and 7 return 0.
- R11: `busRdata` takes the addressed value on the clock edge on which `busRead` is high, and holds it otherwise. A read and a write of the same register in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrite | input | 1 | Write strobe for one cycle |
| busRead | input | 1 | Read strobe for one cycle |
| busAddr | input | 3 | Register offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| padIn | input | 8 | Level sensed at each pad |
| padOut | output | 8 | Drive value for each pad |
| padOe | output | 8 | Drive enable for each pad |
| padPullUp | output | 8 | Pull-up enable for each pad |
| periphIn | output | 8 | Gated, synchronized pin levels for peripherals |

## Verification
Two things can happen in the same cycle:

- A register read and a write to that same register. The bench raises `busRead` and `busWrite` together on the latch offset. It expects the old latch value on the bus, then the new value on the next read.
- A pad change and a pin-level read. The bench changes `padIn` on the same edge on which it starts a burst of back-to-back pin reads. It expects the old level on the first two reads and the new level only on the third, which confirms the depth of the synchronizer.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DIR  = 3'd0,
    SEL_LAT  = 3'd1,
    SEL_PULL = 3'd2,
    SEL_OD   = 3'd3,
    SEL_GATE = 3'd4,
    SEL_PIN  = 3'd5,
    SEL_NONE = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrDir;
    logic    wrLat;
    logic    wrPull;
    logic    wrOd;
    logic    wrGate;
    logic    rdEn;
    regSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             we,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q <= RESET_VAL;
    end else if (we) begin
      q <= d;
    end
  end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) begin
        stage[i] <= '0;
      end
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        stage[i] <= stage[i-1];
      end
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
(
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);

  regSel_e sel;

  always_comb begin
    case (busAddr)
      3'd0:    sel = SEL_DIR;
      3'd1:    sel = SEL_LAT;
      3'd2:    sel = SEL_PULL;
      3'd3:    sel = SEL_OD;
      3'd4:    sel = SEL_GATE;
      3'd5:    sel = SEL_PIN;
      default: sel = SEL_NONE;
    endcase
  end

  always_comb begin
    stb        = '0;
    stb.rdEn   = busRead;
    stb.rdSel  = sel;
    stb.wrDir  = busWrite && (sel == SEL_DIR);
    stb.wrLat  = busWrite && (sel == SEL_LAT);
    stb.wrPull = busWrite && (sel == SEL_PULL);
    stb.wrOd   = busWrite && (sel == SEL_OD);
    stb.wrGate = busWrite && (sel == SEL_GATE);
  end

endmodule

// File: rtl/gpio_dp.sv
module gpio_dp
  import gpio_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter int SYNC_STAGES  = 2,
  parameter bit LATCH_ON_OUT = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padPullUp,
  output logic [WIDTH-1:0] periphIn,
  output logic [WIDTH-1:0] dirQ,
  output logic [WIDTH-1:0] odQ,
  output logic [WIDTH-1:0] gateQ
);

  logic [WIDTH-1:0] latQ;
  logic [WIDTH-1:0] pullQ;
  logic [WIDTH-1:0] pinSync;
  logic [WIDTH-1:0] pinView;
  logic [WIDTH-1:0] rdMux;

  gpio_cfg_reg #(.WIDTH(WIDTH)) u_dirReg (
    .clk(clk), .rstN(rstN), .we(stb.wrDir), .d(busWdata), .q(dirQ)
  );
  gpio_cfg_reg #(.WIDTH(WIDTH)) u_latReg (
    .clk(clk), .rstN(rstN), .we(stb.wrLat), .d(busWdata), .q(latQ)
  );
  gpio_cfg_reg #(.WIDTH(WIDTH)) u_pullReg (
    .clk(clk), .rstN(rstN), .we(stb.wrPull), .d(busWdata), .q(pullQ)
  );
  gpio_cfg_reg #(.WIDTH(WIDTH)) u_odReg (
    .clk(clk), .rstN(rstN), .we(stb.wrOd), .d(busWdata), .q(odQ)
  );
  gpio_cfg_reg #(.WIDTH(WIDTH)) u_gateReg (
    .clk(clk), .rstN(rstN), .we(stb.wrGate), .d(busWdata), .q(gateQ)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .din(padIn), .dout(pinSync)
  );

  // Pad-side controls, computed per pin
  always_comb begin
    padOut    = latQ;
    padOe     = dirQ & ~(odQ & latQ);
    padPullUp = pullQ & ~dirQ;
    periphIn  = pinSync & gateQ;
  end

  generate
    if (LATCH_ON_OUT) begin : g_latchView
      assign pinView = (dirQ & latQ) | (~dirQ & pinSync);
    end else begin : g_pinView
      assign pinView = pinSync;
    end
  endgenerate

  always_comb begin
    case (stb.rdSel)
      SEL_DIR:  rdMux = dirQ;
      SEL_LAT:  rdMux = latQ;
      SEL_PULL: rdMux = pullQ;
      SEL_OD:   rdMux = odQ;
      SEL_GATE: rdMux = gateQ;
      SEL_PIN:  rdMux = pinView;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (stb.rdEn) begin
      busRdata <= rdMux;
    end
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter int SYNC_STAGES  = 2,
  parameter bit LATCH_ON_OUT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WIDTH-1:0]  busWdata,
  output logic [WIDTH-1:0]  busRdata,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  padPullUp,
  output logic [WIDTH-1:0]  periphIn
);

  strobe_t          stb;
  logic [WIDTH-1:0] dirQ;
  logic [WIDTH-1:0] odQ;
  logic [WIDTH-1:0] gateQ;

  gpio_ctrl u_ctrl (
    .busWrite(busWrite),
    .busRead (busRead),
    .busAddr (busAddr),
    .stb     (stb)
  );

  gpio_dp #(
    .WIDTH       (WIDTH),
    .SYNC_STAGES (SYNC_STAGES),
    .LATCH_ON_OUT(LATCH_ON_OUT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe),
    .padPullUp(padPullUp),
    .periphIn (periphIn),
    .dirQ     (dirQ),
    .odQ      (odQ),
    .gateQ    (gateQ)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrite,
  input logic              busRead,
  input logic [ADDR_W-1:0] busAddr,
  input logic [WIDTH-1:0]  busWdata,
  input logic [WIDTH-1:0]  busRdata,
  input logic [WIDTH-1:0]  padOut,
  input logic [WIDTH-1:0]  padOe,
  input logic [WIDTH-1:0]  padPullUp,
  input logic [WIDTH-1:0]  periphIn,
  input logic [WIDTH-1:0]  dirQ,
  input logic [WIDTH-1:0]  odQ,
  input logic [WIDTH-1:0]  gateQ
);

  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == ADDR_W'(0)) |=> (dirQ == $past(busWdata)));

  a_r5_pull_off_on_drive: assert property (@(posedge clk) disable iff (!rstN)
    ((padPullUp & padOe) == '0));

  a_r6_od_never_drives_high: assert property (@(posedge clk) disable iff (!rstN)
    ((odQ & padOe & padOut) == '0));

  a_r7_gate_closed_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((periphIn & ~gateQ) == '0));

  a_r8_out_stable_without_latch_write: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrite && busAddr == ADDR_W'(1)) |=> $stable(padOut));

  a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rstN)
    !busRead |=> $stable(busRdata));

endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .ADDR_W(gpio_pkg::ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWrite (busWrite),
  .busRead  (busRead),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .padOut   (padOut),
  .padOe    (padOe),
  .padPullUp(padPullUp),
  .periphIn (periphIn),
  .dirQ     (dirQ),
  .odQ      (odQ),
  .gateQ    (gateQ)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWrite = 1'b0;
  logic       busRead = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] padIn = '0;
  logic [7:0] rdM, outM, oeM, puM, piM;
  logic [7:0] rdA, outA, oeA, puA, piA;

  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] expM;
    logic [7:0] expA;
    string      tag;
  } item_t;
  item_t expQ[$];
  logic  rdPending = 1'b0;

  always #5 clk = ~clk;

  gpio_port u_dut (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busRead(busRead),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdM), .padIn(padIn),
    .padOut(outM), .padOe(oeM), .padPullUp(puM), .periphIn(piM)
  );

  gpio_port #(.LATCH_ON_OUT(1'b1)) u_dutAlt (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busRead(busRead),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdA), .padIn(padIn),
    .padOut(outA), .padOe(oeA), .padPullUp(puA), .periphIn(piA)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares read results against the scoreboard
  always @(posedge clk) rdPending <= busRead;

  always @(negedge clk) begin
    if (rdPending) begin
      if (expQ.size() == 0) begin
        nCmp++; nBad++;
        $display("FAIL R11 unexpected read result actual=%h expected=none", rdM);
      end else begin
        item_t it;
        it = expQ.pop_front();
        chk(it.tag, rdM, it.expM);
        chk({it.tag, " variant"}, rdA, it.expA);
      end
    end
  end

  // Driver tasks
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rdNow(input logic [2:0] a, input logic [7:0] em, input logic [7:0] ea,
                       input string tag);
    item_t it;
    it.expM = em; it.expA = ea; it.tag = tag;
    expQ.push_back(it);
    busRead = 1'b1; busAddr = a;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] em, input logic [7:0] ea,
                    input string tag);
    @(negedge clk);
    rdNow(a, em, ea, tag);
    @(negedge clk);
    busRead = 1'b0;
  endtask

  function automatic logic [7:0] altPin(input logic [7:0] d, input logic [7:0] l,
                                        input logic [7:0] p);
    return (d & l) | (~d & p);
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [7:0] dir, lat, pin;
    padIn = 8'hA5;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 rdata", rdM, 8'h00);
    chk("R1 padOe", oeM, 8'h00);
    chk("R1 pullup", puM, 8'h00);
    chk("R1 periphIn", piM, 8'h00);
    rstN = 1'b1;
    for (int a = 0; a < 5; a++) rd(3'(a), 8'h00, 8'h00, "R1 register");
    repeat (3) @(negedge clk);

    // R4/R7: pin register, gate closed
    pin = 8'hA5;
    rd(3'd5, pin, pin, "R4 pin level");
    chk("R7 closed gate", piM, 8'h00);
    wr(3'd4, 8'h0F);
    chk("R7 open gate", piM, 8'h05);
    rd(3'd4, 8'h0F, 8'h0F, "R7 gate readback");

    // R3/R8: latch while input
    lat = 8'h3C; dir = 8'h00;
    wr(3'd1, lat);
    rd(3'd1, lat, lat, "R3 latch readback");
    rd(3'd5, pin, pin, "R3 pin not latch");
    chk("R8 padOut as input", outM, lat);
    chk("R2 padOe as input", oeM, 8'h00);

    // R2/R8: direction switch
    dir = 8'hFF;
    wr(3'd0, dir);
    chk("R8 padOut after dir", outM, lat);
    chk("R2 padOe all out", oeM, 8'hFF);
    rd(3'd0, dir, dir, "R2 dir readback");
    dir = 8'h0F;
    wr(3'd0, dir);
    chk("R2 padOe low nibble", oeM, 8'h0F);

    // R5: pull-up forced off on outputs
    wr(3'd2, 8'hFF);
    chk("R5 pullup inputs only", puM, 8'hF0);
    rd(3'd2, 8'hFF, 8'hFF, "R5 pull readback");

    // R6: open drain
    wr(3'd3, 8'h03);
    chk("R6 od latch low drives", oeM, 8'h0F);
    lat = 8'h3F;
    wr(3'd1, lat);
    chk("R6 od latch high released", oeM, 8'h0C);
    chk("R6 padOut", outM, lat);

    // R9: compatibility variant
    rd(3'd5, pin, altPin(dir, lat, pin), "R9 pin view");

    // R10: ignored writes and unmapped reads
    wr(3'd5, 8'h00);
    wr(3'd6, 8'hFF);
    wr(3'd7, 8'hFF);
    rd(3'd5, pin, altPin(dir, lat, pin), "R10 pin write ignored");
    rd(3'd6, 8'h00, 8'h00, "R10 unmapped 6");
    rd(3'd7, 8'h00, 8'h00, "R10 unmapped 7");
    rd(3'd0, dir, dir, "R10 dir kept");
    rd(3'd1, lat, lat, "R10 latch kept");
    rd(3'd3, 8'h03, 8'h03, "R10 od kept");
    rd(3'd4, 8'h0F, 8'h0F, "R10 gate kept");

    // R11: read and write of latch in the same cycle
    @(negedge clk);
    busWrite = 1'b1; busWdata = 8'h81;
    rdNow(3'd1, lat, lat, "R11 read before write");
    @(negedge clk);
    busWrite = 1'b0; busRead = 1'b0;
    lat = 8'h81;
    rd(3'd1, lat, lat, "R11 read after write");
    repeat (3) @(negedge clk);
    chk("R11 rdata held", rdM, lat);

    // R4: synchronizer depth, pad change with back-to-back reads
    @(negedge clk);
    padIn = 8'h5A;
    rdNow(3'd5, pin, altPin(dir, lat, pin), "R4 first read old");
    @(negedge clk);
    rdNow(3'd5, pin, altPin(dir, lat, pin), "R4 second read old");
    @(negedge clk);
    rdNow(3'd5, 8'h5A, altPin(dir, lat, 8'h5A), "R4 third read new");
    @(negedge clk);
    busRead = 1'b0;
    pin = 8'h5A;
    chk("R7 gated new level", piM, 8'h0A);
    chk("R7 variant gated", piA, 8'h0A);
    chk("R5 variant pullup", puA, 8'hF0);
    chk("R6 variant oe", oeA, oeM);
    chk("R8 variant out", outA, outM);

    repeat (2) @(negedge clk);
    if (expQ.size() != 0) begin
      nCmp++; nBad++;
      $display("FAIL R11 missing read results actual=%0d expected=0", expQ.size());
    end
    finishRun();
  end

endmodule